// File: doc/BRIEF.md
# Manual Store/Display Register Access Controller

This block sits between a maintenance panel and the storage resources of a small processor. An operator picks a target with a three-bit select code, sets an address switch word and a data switch word, then presses store or display. When the processor is stopped, the controller decodes the switches for the chosen target and issues one request. The target can be main storage, a general register, a floating-point register, a program status halfword, the instruction counter or a storage protection key. It then waits for that target's done bit and shows the outcome on the data lamps and address lamps.

Each request is a one-cycle strobe on a one-hot target vector. The strobe comes with shared write-enable, address, register, halfword and write-data fields. The addressed resource answers with its own done bit and a shared response word. On a store, the controller echoes the written halfword to the data lamps. On a display, it shows the returned word. In both cases it drives odd parity for each byte of the lamp data. Requests that cannot be carried out are dropped without any access, and an error flag is raised. These are a floating-point register number that is odd or too large, an address beyond the installed storage, and an unused select code.

Top module: `panel_access_ctrl`

## Requirements
- R1: A store or display pulse is acted on only when `cpu_stopped` is 1 and no access is outstanding. Otherwise it causes no request, and the lamps and `sel_err` keep their values.
- R2: The select codes are 0 main storage, 1 general register, 2 floating-point register, 3 instruction counter, 4 program status, 5 protection key. An accepted valid request drives `req_stb` bit number equal to the code for exactly one cycle, starting one cycle after the pulse. `req_we` is 1 for store and 0 for display.
- R3: In main-storage and protection-key modes, `req_addr` is the 18 switches zero-extended to 24 bits with bit 0 forced to 0. If that address is not below the `MEM_BYTES` parameter, no request is issued and `sel_err` is set.
- R4: In general-register mode, `req_reg` = `addr_sw[7:4]` and `req_half` = {0, `addr_sw[0]`}. Bits 3..1 have no effect.
- R5: In floating-point mode, `req_reg` = `addr_sw[7:4]` and `req_half` = `addr_sw[1:0]`. If `addr_sw[7]` or `addr_sw[4]` is 1 (register not 0, 2, 4 or 6), no request is issued and `sel_err` is set.
- R6: In program-status mode, `req_half` = `addr_sw[1:0]`.
- R7: In instruction-counter mode, `req_wdata` carries the 18 address switches. A display there loads the returned 18-bit value, zero-extended, into `addr_lamp`.
- R8: A display completes on the done bit of the addressed target. `disp_data` then takes `rsp_data[15:0]`.
- R9: A store completes on the done bit of the addressed target. `disp_data` then takes the low 16 bits of the written word. `disp_par[1]` and `disp_par[0]` always give odd parity over `disp_data[15:8]` and `disp_data[7:0]`.
- R10: While `busy` is 1, a done bit of any other target neither completes the access nor changes the lamps.
- R11: If store and display pulse together, the store is taken. Select codes 6 and 7 issue no request and set `sel_err`. An accepted valid request clears `sel_err`.
- R12: In modes other than instruction-counter display, `addr_lamp` shows the decoded access address when the request is accepted. In main-storage and protection-key modes this is the aligned address; in the other modes it is the zero-extended switch word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_stopped | input | 1 | Processor is in the stopped state |
| sel_mode | input | 3 | Target select code |
| addr_sw | input | 18 | Address switch word |
| data_sw | input | 16 | Data switch word |
| store_pb | input | 1 | Store pulse |
| display_pb | input | 1 | Display pulse |
| rsp_done | input | 6 | Per-target completion, bit = select code |
| rsp_data | input | 18 | Read data from the responding target |
| req_stb | output | 6 | One-hot single-cycle request strobe |
| req_we | output | 1 | Request is a write |
| req_addr | output | 24 | Storage address for main storage and key modes |
| req_reg | output | 4 | Register number |
| req_half | output | 2 | Halfword index |
| req_wdata | output | 18 | Write data |
| busy | output | 1 | Access outstanding |
| sel_err | output | 1 | Last accepted pulse named an invalid target |
| disp_data | output | 16 | Data lamps |
| disp_par | output | 2 | Odd parity of the data lamp bytes |
| addr_lamp | output | 24 | Address lamps |

## Verification
Random pulses cover all eight select codes with random switch words, random completion delays and an occasional running processor. Their results are compared with a bench model of the decode, the availability limit and the lamp update. Directed cases separate the features the random stream seldom isolates. The don't-care switch bits in register modes are toggled to show they leave the decode unchanged. Floating-point numbers 1, 8 and 6 separate invalid from valid register numbers, and addresses on each side of the installed limit separate suppression from access. A done bit from the wrong target, and a second pulse while busy, show that only the addressed target ends an access. Simultaneous pulses show that store wins.

// File: rtl/panel_access_ctrl.sv
module panel_access_ctrl #(
  parameter int SW_W      = 18,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 24,
  parameter int MEM_BYTES = 262144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_stopped,
  input  logic [2:0]        sel_mode,
  input  logic [SW_W-1:0]   addr_sw,
  input  logic [DATA_W-1:0] data_sw,
  input  logic              store_pb,
  input  logic              display_pb,
  input  logic [5:0]        rsp_done,
  input  logic [SW_W-1:0]   rsp_data,
  output logic [5:0]        req_stb,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [3:0]        req_reg,
  output logic [1:0]        req_half,
  output logic [SW_W-1:0]   req_wdata,
  output logic              busy,
  output logic              sel_err,
  output logic [DATA_W-1:0] disp_data,
  output logic [1:0]        disp_par,
  output logic [ADDR_W-1:0] addr_lamp
);
  localparam logic [2:0] M_MEM = 3'd0, M_GPR = 3'd1, M_FPR = 3'd2,
                         M_IC  = 3'd3, M_PSW = 3'd4, M_KEY = 3'd5;

  logic [2:0] tgt_q;
  logic       st_q;

  wire              take   = cpu_stopped && !busy && (store_pb || display_pb);
  wire [ADDR_W-1:0] mem_ea = ADDR_W'({addr_sw[SW_W-1:1], 1'b0});
  wire              mem_ok = 32'(mem_ea) < MEM_BYTES;
  wire              fpr_ok = !addr_sw[7] && !addr_sw[4];
  wire              done   = busy && rsp_done[tgt_q];

  logic bad;
  always_comb begin
    case (sel_mode)
      M_MEM, M_KEY: bad = !mem_ok;
      M_FPR:        bad = !fpr_ok;
      M_GPR, M_IC, M_PSW: bad = 1'b0;
      default:      bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_stb   <= '0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_reg   <= '0;
      req_half  <= '0;
      req_wdata <= '0;
      busy      <= 1'b0;
      sel_err   <= 1'b0;
      tgt_q     <= '0;
      st_q      <= 1'b0;
      disp_data <= '0;
      addr_lamp <= '0;
    end else begin
      req_stb <= '0;
      if (take) begin
        sel_err <= bad;
        if (!bad) begin
          req_stb   <= 6'(1) << sel_mode;
          req_we    <= store_pb;
          st_q      <= store_pb;
          tgt_q     <= sel_mode;
          busy      <= 1'b1;
          req_addr  <= (sel_mode == M_MEM || sel_mode == M_KEY) ? mem_ea : '0;
          req_reg   <= (sel_mode == M_GPR || sel_mode == M_FPR) ? addr_sw[7:4] : '0;
          req_half  <= (sel_mode == M_GPR) ? {1'b0, addr_sw[0]} :
                       (sel_mode == M_FPR || sel_mode == M_PSW) ? addr_sw[1:0] : '0;
          req_wdata <= (sel_mode == M_IC) ? addr_sw : SW_W'(data_sw);
          addr_lamp <= (sel_mode == M_MEM || sel_mode == M_KEY) ? mem_ea : ADDR_W'(addr_sw);
        end
      end
      if (done) begin
        busy      <= 1'b0;
        disp_data <= st_q ? req_wdata[DATA_W-1:0] : rsp_data[DATA_W-1:0];
        if (!st_q && tgt_q == M_IC) addr_lamp <= ADDR_W'(rsp_data);
      end
    end
  end

  assign disp_par = {~^disp_data[DATA_W-1:8], ~^disp_data[7:0]};

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_stb));
  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_stb != '0) |=> (req_stb == '0));
  // R1
  strobe_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_stb != '0) |-> $past(cpu_stopped && (store_pb || display_pb)));
  // R3
  mem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_stb[0] || req_stb[5]) |-> (req_addr[0] == 1'b0 && 32'(req_addr) < MEM_BYTES));
  // R5
  fpr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_stb[2] |-> (!req_reg[3] && !req_reg[0]));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_done[tgt_q]) |=> busy);
endmodule

// File: tb/panel_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module panel_access_ctrl_tb_top;
  localparam int MEMB = 65536;
  logic clk = 0, rst_n = 0, cpu_stopped = 0, store_pb = 0, display_pb = 0;
  logic [2:0] sel_mode = 0;
  logic [17:0] addr_sw = 0, rsp_data = 0;
  logic [15:0] data_sw = 0;
  logic [5:0] rsp_done = 0;
  logic [5:0] req_stb;
  logic req_we, busy, sel_err;
  logic [23:0] req_addr, addr_lamp;
  logic [3:0] req_reg;
  logic [1:0] req_half, disp_par;
  logic [17:0] req_wdata;
  logic [15:0] disp_data;
  int checks = 0, fails = 0;
  logic [15:0] e_disp = 0;
  logic [23:0] e_lamp = 0;
  logic e_err = 0;

  always #2.5 clk = ~clk;

  panel_access_ctrl #(.MEM_BYTES(MEMB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_stopped(cpu_stopped), .sel_mode(sel_mode),
    .addr_sw(addr_sw), .data_sw(data_sw), .store_pb(store_pb), .display_pb(display_pb),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .req_stb(req_stb), .req_we(req_we),
    .req_addr(req_addr), .req_reg(req_reg), .req_half(req_half), .req_wdata(req_wdata),
    .busy(busy), .sel_err(sel_err), .disp_data(disp_data), .disp_par(disp_par),
    .addr_lamp(addr_lamp));

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [17:0] model(input logic [2:0] m, input logic [17:0] a);
    return 18'(m) * 18'h2345 ^ a * 18'd3 ^ 18'h15a5a;
  endfunction

  function automatic bit is_bad(input logic [2:0] m, input logic [17:0] a);
    case (m)
      3'd0, 3'd5: return 32'({a[17:1], 1'b0}) >= MEMB;
      3'd2: return a[7] || a[4];
      3'd1, 3'd3, 3'd4: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic lamps_chk(input string r);
    chk(disp_data == e_disp, r, disp_data, e_disp);
    chk(disp_par == {~^e_disp[15:8], ~^e_disp[7:0]}, "R9 parity", disp_par, {~^e_disp[15:8], ~^e_disp[7:0]});
    chk(addr_lamp == e_lamp, r, addr_lamp, e_lamp);
    chk(sel_err == e_err, r, sel_err, e_err);
  endtask

  task automatic op(input logic [2:0] m, input logic [17:0] a, input logic [15:0] d,
                    input bit st, input bit ds, input bit stp, input int dly, input bit poke);
    bit wr;
    logic [17:0] rv;
    @(negedge clk);
    sel_mode = m; addr_sw = a; data_sw = d; cpu_stopped = stp; store_pb = st; display_pb = ds;
    @(negedge clk);
    store_pb = 0; display_pb = 0;
    if (!(stp && (st || ds))) begin
      chk(req_stb == 0 && !busy, "R1 ignored pulse", {req_stb, busy}, 0);
      lamps_chk("R1 lamps kept");
      return;
    end
    if (is_bad(m, a)) begin
      e_err = 1;
      chk(req_stb == 0 && !busy, "R3/R5/R11 suppressed", {req_stb, busy}, 0);
      lamps_chk("R11 err flag");
      return;
    end
    wr = st;
    chk(req_stb == 6'(1) << m, "R2 strobe", req_stb, 6'(1) << m);
    chk(req_we == wr, "R2 we", req_we, wr);
    case (m)
      3'd0, 3'd5: chk(req_addr == {6'b0, a[17:1], 1'b0}, "R3 addr", req_addr, {6'b0, a[17:1], 1'b0});
      3'd1: chk({req_reg, req_half} == {a[7:4], 1'b0, a[0]}, "R4 gpr", {req_reg, req_half}, {a[7:4], 1'b0, a[0]});
      3'd2: chk({req_reg, req_half} == {a[7:4], a[1:0]}, "R5 fpr", {req_reg, req_half}, {a[7:4], a[1:0]});
      3'd4: chk(req_half == a[1:0], "R6 psw", req_half, a[1:0]);
      default: ;
    endcase
    chk(req_wdata == ((m == 3'd3) ? a : {2'b0, d}), "R7 wdata", req_wdata, (m == 3'd3) ? a : {2'b0, d});
    e_lamp = (m == 3'd0 || m == 3'd5) ? {6'b0, a[17:1], 1'b0} : {6'b0, a};
    chk(addr_lamp == e_lamp, "R12 addr lamp", addr_lamp, e_lamp);
    chk(busy, "R10 busy", busy, 1);
    if (poke) begin
      sel_mode = 3'd1; display_pb = 1;
      @(negedge clk);
      display_pb = 0;
      chk(req_stb == 0, "R1 pulse while busy", req_stb, 0);
    end
    if (dly > 0) begin
      rsp_done = 6'(1) << ((m + 1) % 6);
      @(negedge clk);
      rsp_done = 0;
      chk(busy && disp_data == e_disp, "R10 foreign done", {busy, disp_data}, {1'b1, e_disp});
      repeat (dly - 1) @(negedge clk);
    end
    rv = model(m, a);
    rsp_done = 6'(1) << m; rsp_data = rv;
    @(negedge clk);
    rsp_done = 0; rsp_data = 18'h3ffff;
    e_err = 0;
    e_disp = wr ? ((m == 3'd3) ? a[15:0] : d) : rv[15:0];
    if (!wr && m == 3'd3) e_lamp = {6'b0, rv};
    chk(!busy, "R8 complete", busy, 0);
    lamps_chk(wr ? "R9 store echo" : "R8 display");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(disp_data == 0 && disp_par == 2'b11, "R9 reset lamps", {disp_data, disp_par}, 3);
    chk(req_stb == 0 && !busy && !sel_err && addr_lamp == 0, "R2 reset", {req_stb, busy, sel_err}, 0);
    rst_n = 1;
    op(3'd0, 18'h01235, 16'hbeef, 1, 0, 0, 0, 0);   // R1 running cpu
    op(3'd0, 18'h01235, 16'hbeef, 1, 0, 1, 0, 0);   // R3 odd address aligned
    op(3'd0, 18'h0fffe, 16'h0000, 0, 1, 1, 2, 0);   // R3 last halfword below limit
    op(3'd0, 18'h10000, 16'h1111, 1, 0, 1, 0, 0);   // R3 at limit suppressed
    op(3'd1, 18'h000a1, 16'h1234, 1, 0, 1, 0, 0);   // R4
    op(3'd1, 18'h000ae, 16'h5678, 0, 1, 1, 1, 0);   // R4 don't-care bits
    op(3'd2, 18'h00010, 16'h0, 0, 1, 1, 0, 0);      // R5 odd reg 1
    op(3'd2, 18'h00080, 16'h0, 0, 1, 1, 0, 0);      // R5 reg 8
    op(3'd2, 18'h0006f, 16'h4321, 1, 0, 1, 0, 0);   // R5 reg 6 half 3
    op(3'd4, 18'h3fffe, 16'h0f0f, 0, 1, 1, 0, 0);   // R6
    op(3'd3, 18'h2abcd, 16'h0, 1, 0, 1, 0, 0);      // R7 store
    op(3'd3, 18'h00000, 16'h0, 0, 1, 1, 3, 1);      // R7 display, R10
    op(3'd5, 18'h00400, 16'h000c, 1, 1, 1, 0, 0);   // R11 store wins
    op(3'd6, 18'h0, 16'h0, 1, 0, 1, 0, 0);          // R11 code 6
    op(3'd7, 18'h0, 16'h0, 0, 1, 1, 0, 0);          // R11 code 7
    op(3'd4, 18'h00001, 16'h0, 0, 1, 1, 0, 0);      // R11 err cleared
    for (int i = 0; i < 400; i++) begin
      logic [17:0] a;
      bit s, dsp;
      a = 18'($urandom);
      s = $urandom % 2;
      dsp = $urandom % 3 != 0;
      op(3'($urandom % 8), a, 16'($urandom), s, dsp, ($urandom % 10) != 0,
         int'($urandom % 3), ($urandom % 8) == 0);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule